// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave with Auto-Stepping Pointer

This block is the slave side of a two-wire (I2C-style) control port in front of a small bank of 8-bit configuration registers. SCL and SDA arrive as plain inputs and are oversampled in the system clock domain. The block answers a 7-bit device address. Six of its bits are fixed, and the lowest one follows a strap pin. The block pulls SDA low through an open-drain style enable output. All registers are also presented in parallel on a flat output bus, so the surrounding logic can use them directly.

In a write transfer, the first byte after the address byte loads an 8-bit pointer. Bit 7 of the pointer is a step flag and bits 6:0 select a register. Every byte after that is stored into the selected register. A read transfer has no pointer byte. It begins with the register the pointer already holds, so a read either picks up where the last write left the pointer, or uses the value set at reset. When the step flag is set, the pointer advances after each acknowledged data byte. This makes multi-byte bursts possible in both directions. Past the last implemented register, the pointer wraps to register 1.

Top module: `i2cp_slave`

## Requirements
- R1: The slave acknowledges (drives SDA low in the ninth clock) an address byte whose bits 7:2 are 001100 and whose bit 1 equals `addr_strap`. Bit 0 of that byte is the direction: 0 for a write, 1 for a read.
- R2: When bits 7:1 of the address byte do not match, the slave leaves SDA released in the ninth clock. It ignores all later bytes (no acknowledge, no register change) until the next START.
- R3: In a write transfer, the byte after the address byte is loaded into the pointer, and the slave acknowledges it. Each following byte is written to the register given by pointer bits 6:0, and the slave acknowledges each one.
- R4: A read transfer sends, MSB first, the register selected by the pointer as it stood at the START. The pointer keeps its last written value across transfers.
- R5: After reset, the pointer is 0x01, register i holds 0xA0 + i, and SDA is released.
- R6: With pointer bit 7 set, the pointer advances by one after each data byte written and after each read byte the master acknowledges (SDA low in the ninth clock).
- R7: With pointer bit 7 clear, the pointer does not move: consecutive written bytes land in the same register, and consecutive read bytes repeat the same register.
- R8: When a step would pass register NREG-1, or the pointer addresses a register at or above NREG, the next pointer address is 0x01. Bit 7 is kept.
- R9: When the master does not acknowledge a read byte, the slave releases SDA and drives nothing until the next START.
- R10: A STOP at any point returns the slave to idle with SDA released, and a byte cut short by it writes nothing. A repeated START begins a new address phase.
- R11: The slave changes its SDA drive only while SCL is low, so data it sends is stable for the whole high phase of SCL.
- R12: Writes to register addresses at or above NREG change nothing, and reads of them return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock level |
| sda_in | input | 1 | Bus data level (wired, after the open-drain driver) |
| addr_strap | input | 1 | Strap that sets bit 1 of the address byte |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| regs_flat | output | NREG*8 | All registers, register i at bits i*8+7 : i*8 |

## Verification
Two things happen in the same clock cycle at the end of every data byte when the step flag is set. The register write strobe fires at the old pointer, and the pointer moves to its next value, possibly wrapping. The matching case on the read side is the master acknowledge cycle: the read port looks ahead to the next pointer while the pointer itself updates. The bench provokes both with a stepped burst write that crosses the last register, followed by an implicit stepped burst read. It judges the outcome from the parallel register output, the wrapped landing register, and the byte values shifted out on SDA.

// File: rtl/i2cp_pkg.sv
package i2cp_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AACK, S_MAP, S_MACK, S_WDAT, S_WACK, S_RDAT, S_RACK
  } st_t;
  localparam logic [5:0] DEV_HI = 6'b001100;
  localparam int PTR_AW = 7;
endpackage

// File: rtl/i2cp_line_sync.sv
module i2cp_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_sr, sda_sr;
  logic scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[SYNC_STAGES-2:0], scl_in};
      sda_sr <= {sda_sr[SYNC_STAGES-2:0], sda_in};
      scl_p  <= scl_sr[SYNC_STAGES-1];
      sda_p  <= sda_sr[SYNC_STAGES-1];
    end
  end

  assign scl_q     = scl_sr[SYNC_STAGES-1];
  assign sda_q     = sda_sr[SYNC_STAGES-1];
  assign scl_rise  = scl_q & ~scl_p;
  assign scl_fall  = ~scl_q & scl_p;
  assign start_det = scl_q & scl_p & sda_p & ~sda_q;
  assign stop_det  = scl_q & scl_p & ~sda_p & sda_q;
endmodule

// File: rtl/i2cp_regbank.sv
module i2cp_regbank #(
  parameter int NREG = 8,
  parameter int DW = 8,
  parameter int AW = 7,
  parameter logic [7:0] RST_SEED = 8'hA0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [AW-1:0]   rd_addr,
  output logic [DW-1:0]   rd_data,
  output logic [NREG*DW-1:0] regs_flat
);
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;
  logic [DW-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) regs[g] <= DW'(RST_SEED) | DW'(g);
      else if (wr_en && wr_addr == AW'(g)) regs[g] <= wr_data;
    end
    assign regs_flat[g*DW +: DW] = regs[g];
  end

  assign rd_data = (rd_addr < AW'(NREG)) ? regs[rd_addr[IW-1:0]] : '0;

  AST_WR_LANDS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr < AW'(NREG)) |=> regs[$past(wr_addr[IW-1:0])] == $past(wr_data)); // R3
  AST_WR_OUT_RANGE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr >= AW'(NREG)) |=> $stable(regs_flat)); // R12
endmodule

// File: rtl/i2cp_slave.sv
module i2cp_slave
  import i2cp_pkg::*;
#(
  parameter int NREG = 8,
  parameter logic [7:0] MAP_RESET = 8'h01,
  parameter logic [7:0] RST_SEED = 8'hA0,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  input  logic addr_strap,
  output logic sda_oe,
  output logic [NREG*8-1:0] regs_flat
);
  localparam int AW = PTR_AW;
  localparam int LAST = NREG - 1;

  logic scl_q, sda_q, scl_rise, scl_fall, start_det, stop_det;
  st_t st;
  logic [3:0] cnt;
  logic [7:0] sr;
  logic [6:0] tx;
  logic [7:0] map_q;
  logic rw_q, oe_q, mack_q;
  logic [AW-1:0] nxt_ptr, rd_addr;
  logic [7:0] rd_data;
  logic byte_end, addr_match, wr_en, step;

  i2cp_line_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  assign byte_end   = scl_fall && cnt == 4'd8;
  assign addr_match = sr[7:1] == {DEV_HI, addr_strap};
  assign nxt_ptr    = (map_q[6:0] >= AW'(LAST)) ? AW'(1) : map_q[6:0] + AW'(1);
  assign rd_addr    = (st == S_RACK && map_q[7]) ? nxt_ptr : map_q[6:0];
  assign wr_en      = (st == S_WDAT) && byte_end && !start_det && !stop_det;
  assign step       = map_q[7] && !start_det && !stop_det &&
                      ((st == S_WDAT && byte_end) || (st == S_RACK && scl_fall && mack_q));

  i2cp_regbank #(.NREG(NREG), .DW(8), .AW(AW), .RST_SEED(RST_SEED)) i_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(map_q[6:0]), .wr_data(sr),
    .rd_addr(rd_addr), .rd_data(rd_data), .regs_flat(regs_flat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; cnt <= '0; sr <= '0; tx <= '0;
      map_q <= MAP_RESET; rw_q <= 1'b0; oe_q <= 1'b0; mack_q <= 1'b0;
    end else if (stop_det) begin
      st <= S_IDLE; oe_q <= 1'b0;
    end else if (start_det) begin
      st <= S_ADDR; cnt <= '0; oe_q <= 1'b0;
    end else begin
      if (scl_rise) begin
        sr <= {sr[6:0], sda_q};
        if (cnt != 4'd8) cnt <= cnt + 4'd1;
        if (st == S_RACK) mack_q <= ~sda_q;
      end
      case (st)
        S_ADDR: if (byte_end) begin
          if (addr_match) begin
            oe_q <= 1'b1; rw_q <= sr[0]; st <= S_AACK;
          end else st <= S_IDLE;
        end
        S_AACK: if (scl_fall) begin
          cnt <= '0;
          if (rw_q) begin
            tx <= rd_data[6:0]; oe_q <= ~rd_data[7]; st <= S_RDAT;
          end else begin
            oe_q <= 1'b0; st <= S_MAP;
          end
        end
        S_MAP: if (byte_end) begin
          map_q <= sr; oe_q <= 1'b1; st <= S_MACK;
        end
        S_MACK, S_WACK: if (scl_fall) begin
          oe_q <= 1'b0; cnt <= '0; st <= S_WDAT;
        end
        S_WDAT: if (byte_end) begin
          oe_q <= 1'b1; st <= S_WACK;
          if (map_q[7]) map_q <= {map_q[7], nxt_ptr};
        end
        S_RDAT: if (scl_fall) begin
          if (cnt == 4'd8) begin
            oe_q <= 1'b0; cnt <= '0; st <= S_RACK;
          end else begin
            oe_q <= ~tx[6]; tx <= {tx[5:0], 1'b0};
          end
        end
        S_RACK: if (scl_fall) begin
          cnt <= '0;
          if (mack_q) begin
            if (map_q[7]) map_q <= {map_q[7], nxt_ptr};
            tx <= rd_data[6:0]; oe_q <= ~rd_data[7]; st <= S_RDAT;
          end else begin
            oe_q <= 1'b0; st <= S_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe = oe_q;

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(oe_q) |-> $past(!scl_q || start_det || stop_det)); // R11
  AST_ADDR_MISS: assert property (@(posedge clk) disable iff (rst)
    (st == S_ADDR && byte_end && !addr_match && !start_det && !stop_det)
      |=> (st == S_IDLE && !oe_q)); // R2
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (st == S_IDLE && !oe_q)); // R10
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (step && map_q[6:0] >= AW'(LAST)) |=> map_q[6:0] == AW'(1)); // R8
  AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (st == S_RACK && scl_fall && !mack_q && !start_det && !stop_det)
      |=> (!oe_q && st == S_IDLE)); // R9
endmodule

// File: tb/test_i2cp_slave.sv
module test_i2cp_slave;
  localparam int NREG = 8;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1, strap = 1'b0;
  logic sda_oe;
  logic [NREG*8-1:0] regs_flat;
  wire  sda_line = sda_oe ? 1'b0 : sda_m;
  int nchk = 0, nerr = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  i2cp_slave #(.NREG(NREG)) i_i2cp_slave (
    .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line),
    .addr_strap(strap), .sda_oe(sda_oe), .regs_flat(regs_flat)
  );

  // op: 1 = single write {ptr,data}, 2 = pointer write then read, expect
  localparam logic [25:0] VEC [8] = '{
    {2'd1, 8'h02, 8'h3C, 8'h00},
    {2'd1, 8'h05, 8'hC3, 8'h00},
    {2'd2, 8'h02, 8'h00, 8'h3C},
    {2'd2, 8'h05, 8'h00, 8'hC3},
    {2'd2, 8'h00, 8'h00, 8'hA0},
    {2'd1, 8'h10, 8'h55, 8'h00},
    {2'd2, 8'h10, 8'h00, 8'h00},
    {2'd2, 8'h06, 8'h00, 8'hA6}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rg(input int i);
    return regs_flat[i*8 +: 8];
  endfunction

  task automatic send_bit(input logic b, output logic s1, output logic s2);
    sda_m = b; tick(5);
    scl_m = 1'b1; tick(5);
    s1 = sda_line; tick(5);
    s2 = sda_line;
    scl_m = 1'b0; tick(5);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(5);
    scl_m = 1'b1; tick(5);
    sda_m = 1'b0; tick(5);
    scl_m = 1'b0; tick(5);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(5);
    scl_m = 1'b1; tick(5);
    sda_m = 1'b1; tick(5);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic s1, s2;
    for (int i = 7; i >= 0; i--) send_bit(b[i], s1, s2);
    send_bit(1'b1, s1, s2);
    ack = ~s1;
  endtask

  task automatic rd_byte(output logic [7:0] b, input logic mack, output logic stab);
    logic s1, s2;
    stab = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      send_bit(1'b1, s1, s2);
      b[i] = s1;
      if (s1 !== s2) stab = 1'b0;
    end
    send_bit(~mack, s1, s2);
  endtask

  function automatic logic [7:0] dev(input logic rd);
    return {6'b001100, strap, rd};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic a;
    logic st;
    logic [7:0] d;
    tick(5); rst = 1'b0; tick(5);

    // R5 reset state
    check("R5 sda released", {7'd0, sda_line}, 8'h01);
    check("R5 reg0 reset", rg(0), 8'hA0);
    check("R5 reg7 reset", rg(7), 8'hA7);

    // R4/R5 read before any write uses default pointer 0x01
    bus_start(); wr_byte(dev(1'b1), a);
    check("R1 read addr ack", {7'd0, a}, 8'h01);
    rd_byte(d, 1'b0, st); bus_stop();
    check("R4 default pointer read", d, 8'hA1);
    check("R11 data stable while SCL high", {7'd0, st}, 8'h01);

    // vector table: R1 R3 R4 R12
    foreach (VEC[k]) begin
      bus_start(); wr_byte(dev(1'b0), a);
      check("R1 write addr ack", {7'd0, a}, 8'h01);
      wr_byte(VEC[k][23:16], a);
      check("R3 pointer byte ack", {7'd0, a}, 8'h01);
      if (VEC[k][25:24] == 2'd1) begin
        wr_byte(VEC[k][15:8], a); bus_stop();
        check("R3 data byte ack", {7'd0, a}, 8'h01);
        if (VEC[k][22:16] < 7'(NREG))
          check("R3 register written", rg(int'(VEC[k][22:16])), VEC[k][15:8]);
        else
          check("R12 out of range write ignored", rg(2), 8'h3C);
      end else begin
        bus_start(); wr_byte(dev(1'b1), a);
        rd_byte(d, 1'b0, st); bus_stop();
        check("R4 R12 pointer read", d, VEC[k][7:0]);
      end
    end

    // R4 implicit resume at last written pointer (0x06)
    bus_start(); wr_byte(dev(1'b1), a);
    rd_byte(d, 1'b0, st); bus_stop();
    check("R4 resume at last pointer", d, 8'hA6);

    // R6 R8 stepped burst write across the last register
    bus_start(); wr_byte(dev(1'b0), a); wr_byte(8'h86, a);
    wr_byte(8'h61, a); wr_byte(8'h71, a); wr_byte(8'h11, a); bus_stop();
    check("R6 burst reg6", rg(6), 8'h61);
    check("R6 burst reg7", rg(7), 8'h71);
    check("R8 wrap lands on reg1", rg(1), 8'h11);
    check("R8 reg0 skipped", rg(0), 8'hA0);

    // R6 implicit stepped burst read from pointer 0x82
    bus_start(); wr_byte(dev(1'b1), a);
    rd_byte(d, 1'b1, st); check("R6 burst read 1", d, 8'h3C);
    rd_byte(d, 1'b1, st); check("R6 burst read 2", d, 8'hA3);
    rd_byte(d, 1'b0, st); check("R6 burst read 3", d, 8'hA4);
    check("R11 burst data stable", {7'd0, st}, 8'h01);
    bus_stop();

    // R7 no step: repeated read and repeated write
    bus_start(); wr_byte(dev(1'b0), a); wr_byte(8'h05, a);
    bus_start(); wr_byte(dev(1'b1), a);
    rd_byte(d, 1'b1, st); check("R7 repeat read 1", d, 8'hC3);
    rd_byte(d, 1'b0, st); check("R7 repeat read 2", d, 8'hC3);
    bus_stop();
    bus_start(); wr_byte(dev(1'b0), a); wr_byte(8'h03, a);
    wr_byte(8'h11, a); wr_byte(8'h22, a); bus_stop();
    check("R7 same register last value", rg(3), 8'h22);
    check("R7 neighbour untouched", rg(4), 8'hA4);

    // R9 master NACK releases SDA
    bus_start(); wr_byte(dev(1'b1), a);
    rd_byte(d, 1'b0, st);
    rd_byte(d, 1'b0, st);
    check("R9 no drive after NACK", d, 8'hFF);
    bus_stop();

    // R2 mismatched address (strap now 1, byte carries 0)
    strap = 1'b1; tick(5);
    bus_start(); wr_byte(8'h30, a);
    check("R2 address NACK", {7'd0, a}, 8'h00);
    wr_byte(8'h01, a);
    check("R2 later byte ignored", {7'd0, a}, 8'h00);
    wr_byte(8'h5A, a); bus_stop();
    check("R2 no register change", rg(1), 8'h11);
    bus_start(); wr_byte(dev(1'b0), a);
    check("R1 strap-high address ack", {7'd0, a}, 8'h01);
    wr_byte(8'h01, a); wr_byte(8'h99, a); bus_stop();
    check("R1 strap-high write", rg(1), 8'h99);

    // R10 STOP inside a data byte writes nothing
    bus_start(); wr_byte(dev(1'b0), a); wr_byte(8'h07, a);
    begin
      logic s1, s2;
      for (int i = 0; i < 4; i++) send_bit(1'b0, s1, s2);
    end
    bus_stop();
    check("R10 cut byte not written", rg(7), 8'h71);
    check("R10 SDA released after STOP", {7'd0, sda_line}, 8'h01);

    // R10 repeated START begins new address phase
    bus_start(); wr_byte(dev(1'b0), a); wr_byte(8'h02, a);
    bus_start(); wr_byte(dev(1'b1), a);
    check("R10 repeated START addr ack", {7'd0, a}, 8'h01);
    rd_byte(d, 1'b0, st); bus_stop();
    check("R10 read after repeated START", d, 8'h3C);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule